// File: doc/BRIEF.md
# Video Input Sync and Field Extractor

This block sits at the input of a video scaler. It takes an 8-bit byte-serial YCbCr 4:2:2 stream on the stream's own clock, with a data qualifier and separate horizontal and vertical reference inputs. From these it produces single-cycle horizontal and vertical acquisition-window triggers, a field identifier, and a strobed data stream for the scaler to consume.

Timing comes from one of two sources. The first is the reference pins, where the trigger edges can be selected. The second is the embedded BT.656 timing words carried in the data. A configuration bit chooses the source. A change of source takes effect only at the next line start of the source already in use, and an output port shows which source is active. The field identifier is decoded in one of three ways. In embedded mode it comes from the F bit. In pin mode it is either the phase of the vertical-reference edge combined with the horizontal-reference level, or a frame-sync level carried on the vertical-reference pin.

Every accepted byte leaves the block three accepted bytes later. This delay lets the block remove a complete timing word from the stream once it has been recognised.

Top module: `vid_sync_extract`

## Requirements
- R1: While reset is asserted and on its release, `h_trig`, `v_trig`, `field_id` and `pix_vld` are 0 and `src_codes` is 0 (reference pins active).
- R2: In pin mode, `h_trig` pulses for exactly one cycle, on the clock edge where `href_in` is first sampled at its new level. It pulses on the rising edge when `cfg_h_fall`=0 and on the falling edge when `cfg_h_fall`=1.
- R3: In pin mode, `v_trig` pulses for one cycle on a `vref_in` edge. `cfg_v_sel`=00 selects rising edges, 01 selects falling edges, and 10 or 11 selects both.
- R4: In pin mode with `cfg_fid_level`=0, on any `vref_in` edge `field_id` becomes (edge is falling) XOR (`href_in` level in that same cycle). Otherwise `field_id` holds its value.
- R5: In pin mode with `cfg_fid_level`=1, `field_id` equals `vref_in` as sampled on the previous clock edge.
- R6: A byte is taken when `pix_qual_in` is 1, or when it is 0 if `cfg_qual_low`=1. A byte that is not taken never appears on `pix_out`.
- R7: With `cfg_gated`=1, every byte is taken, whatever the qualifier says.
- R8: Taken bytes reappear in order on `pix_out`. Each is strobed by `pix_vld` on the clock edge that takes the third taken byte after it. `pix_vld` is never high one cycle after a non-taken byte. In pin mode, timing words pass through unchanged.
- R9: `src_codes` takes the value of `cfg_use_codes` only on the cycle when the currently active source raises its selected horizontal trigger.
- R10: In embedded mode, a timing word is the run FF, 00, 00, XY on consecutive taken bytes. In XY, bit 6 is F, bit 5 is V and bit 4 is H, and bits 3:0 are ignored. Transitions of H and V drive `h_trig` and `v_trig` under the same edge selections as the pins. `field_id` becomes F. All three outputs take effect one cycle after XY is taken.
- R11: In embedded mode, all four bytes of a timing word are removed from `pix_out`. Incomplete preambles (for example FF, 00, 12) are passed through.
- R12: In embedded mode, `href_in` and `vref_in` have no effect on `h_trig`, `v_trig` or `field_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream input clock |
| rst_n | input | 1 | Active-low reset |
| pix_in | input | DW | Byte-serial video data |
| pix_qual_in | input | 1 | Data qualifier |
| href_in | input | 1 | Horizontal reference |
| vref_in | input | 1 | Vertical reference |
| cfg_use_codes | input | 1 | 1 = take timing from embedded words |
| cfg_h_fall | input | 1 | 1 = horizontal trigger on falling transition |
| cfg_v_sel | input | 2 | Vertical trigger edge: 00 rise, 01 fall, 1x both |
| cfg_fid_level | input | 1 | 1 = vertical pin carries odd/even level |
| cfg_qual_low | input | 1 | 1 = qualifier active low |
| cfg_gated | input | 1 | 1 = every byte taken |
| h_trig | output | 1 | Horizontal window trigger pulse |
| v_trig | output | 1 | Vertical window trigger pulse |
| field_id | output | 1 | Field identifier |
| pix_out | output | DW | Delayed data byte |
| pix_vld | output | 1 | Strobe for pix_out |
| src_codes | output | 1 | 1 = embedded words are the active source |

## Verification
Corruption of the preamble tracker shows up at once. A missed word leaves its four bytes in `pix_out` three taken bytes later, and a false word drops real bytes and produces a trigger one cycle after the byte that completed it. A stale stored H or V level produces a trigger with the wrong sense, or a missing trigger, on the very next timing word. A wrong source register is seen on `src_codes` the cycle after a line start, and from then on the triggers follow the wrong inputs. The bench compares whole output streams and checks the triggers on the exact cycle after each event.

// File: rtl/vse_pkg.sv
package vse_pkg;
  localparam int PRE_LEN = 3;  // FF 00 00 ahead of the timing byte

  typedef enum logic [1:0] {S_IDLE, S_FF, S_Z1, S_Z2} pre_st_e;

  // byte acceptance from qualifier, its polarity and gated mode
  function automatic logic take_byte(input logic q, input logic q_low, input logic gated);
    return gated | (q ^ q_low);
  endfunction

  // edge choice: 00 rise, 01 fall, 1x both
  function automatic logic edge_pick(input logic rise, input logic fall, input logic [1:0] sel);
    case (sel)
      2'b00:   return rise;
      2'b01:   return fall;
      default: return rise | fall;
    endcase
  endfunction

  // field from edge phase and horizontal level
  function automatic logic phase_field(input logic was_fall, input logic h_lvl);
    return was_fall ^ h_lvl;
  endfunction
endpackage

// File: rtl/vse_edge_det.sv
module vse_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/vse_code_det.sv
module vse_code_det
  import vse_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic          code_hit
);
  pre_st_e st_q;
  logic all_one, all_zero;

  assign all_one  = (din == {DW{1'b1}});
  assign all_zero = (din == {DW{1'b0}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else if (take) begin
      if (st_q == S_Z2)                 st_q <= S_IDLE;
      else if (all_one)                 st_q <= S_FF;
      else if (all_zero && st_q == S_FF) st_q <= S_Z1;
      else if (all_zero && st_q == S_Z1) st_q <= S_Z2;
      else                              st_q <= S_IDLE;
    end
  end

  assign code_hit = take && (st_q == S_Z2);
endmodule

// File: rtl/vse_byte_delay.sv
module vse_byte_delay #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          squash,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
      for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
    end else begin
      dout_vld <= 1'b0;
      if (take) begin
        if (squash) begin
          vld_q <= '0;
        end else begin
          dout     <= dat_q[DEPTH-1];
          dout_vld <= vld_q[DEPTH-1];
          for (int i = DEPTH-1; i > 0; i--) dat_q[i] <= dat_q[i-1];
          dat_q[0] <= din;
          vld_q    <= {vld_q[DEPTH-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/vid_sync_extract.sv
module vid_sync_extract
  import vse_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pix_in,
  input  logic          pix_qual_in,
  input  logic          href_in,
  input  logic          vref_in,
  input  logic          cfg_use_codes,
  input  logic          cfg_h_fall,
  input  logic [1:0]    cfg_v_sel,
  input  logic          cfg_fid_level,
  input  logic          cfg_qual_low,
  input  logic          cfg_gated,
  output logic          h_trig,
  output logic          v_trig,
  output logic          field_id,
  output logic [DW-1:0] pix_out,
  output logic          pix_vld,
  output logic          src_codes
);
  localparam int F_POS = DW - 2;
  localparam int V_POS = DW - 3;
  localparam int H_POS = DW - 4;
  localparam int NREF  = 2;  // index 0 horizontal, 1 vertical

  logic            take;
  logic            code_hit, code_squash, line_evt;
  logic [NREF-1:0] pin_lvl, pin_rise, pin_fall;
  logic            h_code_q, v_code_q;
  logic            c_h_rise, c_h_fall, c_v_rise, c_v_fall;
  logic            pin_h_evt, pin_v_evt, code_h_evt, code_v_evt;
  logic            h_evt, v_evt, fid_next;

  assign take    = take_byte(pix_qual_in, cfg_qual_low, cfg_gated);
  assign pin_lvl = {vref_in, href_in};

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    vse_edge_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pin_lvl[g]),
      .rise (pin_rise[g]),
      .fall (pin_fall[g])
    );
  end

  vse_code_det #(.DW(DW)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .din     (pix_in),
    .code_hit(code_hit)
  );

  assign c_h_rise = code_hit &  pix_in[H_POS] & ~h_code_q;
  assign c_h_fall = code_hit & ~pix_in[H_POS] &  h_code_q;
  assign c_v_rise = code_hit &  pix_in[V_POS] & ~v_code_q;
  assign c_v_fall = code_hit & ~pix_in[V_POS] &  v_code_q;

  assign pin_h_evt  = edge_pick(pin_rise[0], pin_fall[0], {1'b0, cfg_h_fall});
  assign pin_v_evt  = edge_pick(pin_rise[1], pin_fall[1], cfg_v_sel);
  assign code_h_evt = edge_pick(c_h_rise, c_h_fall, {1'b0, cfg_h_fall});
  assign code_v_evt = edge_pick(c_v_rise, c_v_fall, cfg_v_sel);

  assign h_evt       = src_codes ? code_h_evt : pin_h_evt;
  assign v_evt       = src_codes ? code_v_evt : pin_v_evt;
  assign line_evt    = h_evt;
  assign code_squash = code_hit & src_codes;

  always_comb begin
    fid_next = field_id;
    if (src_codes) begin
      if (code_hit) fid_next = pix_in[F_POS];
    end else if (cfg_fid_level) begin
      fid_next = vref_in;
    end else if (pin_rise[1] | pin_fall[1]) begin
      fid_next = phase_field(pin_fall[1], href_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_trig    <= 1'b0;
      v_trig    <= 1'b0;
      field_id  <= 1'b0;
      h_code_q  <= 1'b0;
      v_code_q  <= 1'b0;
      src_codes <= 1'b0;
    end else begin
      h_trig   <= h_evt;
      v_trig   <= v_evt;
      field_id <= fid_next;
      if (code_hit) begin
        h_code_q <= pix_in[H_POS];
        v_code_q <= pix_in[V_POS];
      end
      if (line_evt) src_codes <= cfg_use_codes;
    end
  end

  vse_byte_delay #(.DW(DW), .DEPTH(PRE_LEN)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .squash  (code_squash),
    .din     (pix_in),
    .dout    (pix_out),
    .dout_vld(pix_vld)
  );
endmodule

// File: rtl/vse_checker.sv
module vse_checker (
  input logic clk,
  input logic rst_n,
  input logic take,
  input logic code_hit,
  input logic code_squash,
  input logic line_evt,
  input logic h_trig,
  input logic field_id,
  input logic pix_vld,
  input logic src_codes
);
  // R2: a trigger pulse lasts one cycle while the source is unchanged
  a_r2_h_single: assert property (@(posedge clk) disable iff (!rst_n)
    (h_trig && $stable(src_codes)) |=> !h_trig);

  // R8: a strobe only follows a taken byte
  a_r8_vld_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(take));

  // R9: source changes only after a line start
  a_r9_src_at_line: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_codes) |-> $past(line_evt));

  // R10: in embedded mode the field holds between timing words
  a_r10_fid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_codes && !code_hit) |=> $stable(field_id));

  // R11: a removed timing word yields no strobe
  a_r11_squash: assert property (@(posedge clk) disable iff (!rst_n)
    code_squash |=> !pix_vld);

  // R12: in embedded mode a trigger needs a timing word
  a_r12_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (src_codes && !code_hit) |=> !h_trig);
endmodule

bind vid_sync_extract vse_checker u_vse_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .take       (take),
  .code_hit   (code_hit),
  .code_squash(code_squash),
  .line_evt   (line_evt),
  .h_trig     (h_trig),
  .field_id   (field_id),
  .pix_vld    (pix_vld),
  .src_codes  (src_codes)
);

// File: tb/test_vid_sync_extract.sv
module test_vid_sync_extract;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pix_in;
  logic       pix_qual_in, href_in, vref_in;
  logic       cfg_use_codes, cfg_h_fall, cfg_fid_level, cfg_qual_low, cfg_gated;
  logic [1:0] cfg_v_sel;
  logic       h_trig, v_trig, field_id, pix_vld, src_codes;
  logic [7:0] pix_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] got[$];
  logic [7:0] expq[$];

  always #(CLK_P/2) clk = ~clk;

  vid_sync_extract #(.DW(8)) i_vid_sync_extract (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_qual_in(pix_qual_in),
    .href_in(href_in), .vref_in(vref_in), .cfg_use_codes(cfg_use_codes),
    .cfg_h_fall(cfg_h_fall), .cfg_v_sel(cfg_v_sel), .cfg_fid_level(cfg_fid_level),
    .cfg_qual_low(cfg_qual_low), .cfg_gated(cfg_gated), .h_trig(h_trig),
    .v_trig(v_trig), .field_id(field_id), .pix_out(pix_out), .pix_vld(pix_vld),
    .src_codes(src_codes)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (pix_vld) got.push_back(pix_out);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pix_in = 8'h00; pix_qual_in = 1'b0; href_in = 1'b0; vref_in = 1'b0;
    cfg_use_codes = 1'b0; cfg_h_fall = 1'b0; cfg_v_sel = 2'b00;
    cfg_fid_level = 1'b0; cfg_qual_low = 1'b0; cfg_gated = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    got.delete();
    expq.delete();
  endtask

  task automatic send(input logic [7:0] d, input logic q);
    pix_in = d; pix_qual_in = q;
    tick();
    pix_qual_in = 1'b0;
  endtask

  task automatic send_code(input logic [7:0] xy);
    send(8'hFF, 1'b1); send(8'h00, 1'b1); send(8'h00, 1'b1); send(xy, 1'b1);
  endtask

  task automatic cmp_stream(input string req);
    chk({req, " count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk({req, " byte"}, got[i], expq[i]);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 h_trig", h_trig, 0); chk("R1 v_trig", v_trig, 0);
    chk("R1 field_id", field_id, 0); chk("R1 pix_vld", pix_vld, 0);
    chk("R1 src_codes", src_codes, 0);
  endtask

  task automatic t_h_edges();
    do_reset();
    href_in = 1'b1; tick(); chk("R2 rise pulse", h_trig, 1);
    tick(); chk("R2 one cycle", h_trig, 0);
    href_in = 1'b0; tick(); chk("R2 fall ignored", h_trig, 0);
    cfg_h_fall = 1'b1;
    href_in = 1'b1; tick(); chk("R2 rise ignored", h_trig, 0);
    href_in = 1'b0; tick(); chk("R2 fall pulse", h_trig, 1);
    tick(); chk("R2 fall one cycle", h_trig, 0);
  endtask

  task automatic t_v_edges();
    do_reset();
    vref_in = 1'b1; tick(); chk("R3 rise sel rise", v_trig, 1);
    vref_in = 1'b0; tick(); chk("R3 rise sel fall", v_trig, 0);
    cfg_v_sel = 2'b01;
    vref_in = 1'b1; tick(); chk("R3 fall sel rise", v_trig, 0);
    vref_in = 1'b0; tick(); chk("R3 fall sel fall", v_trig, 1);
    cfg_v_sel = 2'b10;
    vref_in = 1'b1; tick(); chk("R3 both rise", v_trig, 1);
    vref_in = 1'b0; tick(); chk("R3 both fall", v_trig, 1);
    tick(); chk("R3 quiet", v_trig, 0);
  endtask

  task automatic t_phase_fid();
    do_reset();
    href_in = 1'b1; tick(); chk("R4 hold w/o vedge", field_id, 0);
    vref_in = 1'b1; tick(); chk("R4 rise href1", field_id, 1);
    tick(); chk("R4 hold", field_id, 1);
    vref_in = 1'b0; tick(); chk("R4 fall href1", field_id, 0);
    href_in = 1'b0; tick();
    vref_in = 1'b1; tick(); chk("R4 rise href0", field_id, 0);
    vref_in = 1'b0; tick(); chk("R4 fall href0", field_id, 1);
  endtask

  task automatic t_level_fid();
    do_reset();
    cfg_fid_level = 1'b1;
    vref_in = 1'b1; tick(); chk("R5 level high", field_id, 1);
    tick(); chk("R5 level steady", field_id, 1);
    vref_in = 1'b0; tick(); chk("R5 level low", field_id, 0);
  endtask

  task automatic t_qual_pol();
    do_reset();
    cfg_qual_low = 1'b1;
    send(8'hA1, 1'b0); send(8'hEE, 1'b1); send(8'hA2, 1'b0);
    send(8'hEF, 1'b1); send(8'hA3, 1'b0); send(8'hA4, 1'b0);
    repeat (3) send(8'h10, 1'b0);
    expq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    cmp_stream("R6 active-low stream");
  endtask

  task automatic t_gated();
    do_reset();
    cfg_gated = 1'b1;
    send(8'hB1, 1'b0); send(8'hB2, 1'b1); send(8'hB3, 1'b0);
    repeat (3) send(8'h10, 1'b0);
    expq = '{8'hB1, 8'hB2, 8'hB3};
    cmp_stream("R7 gated stream");
  endtask

  task automatic t_pass();
    do_reset();
    send(8'h01, 1'b1); chk("R8 no early vld", pix_vld, 0);
    send(8'h5A, 1'b0); chk("R8 no vld on idle", pix_vld, 0);
    send(8'h02, 1'b1); send(8'h03, 1'b1); chk("R8 still empty", pix_vld, 0);
    send(8'h04, 1'b1); chk("R8 latency vld", pix_vld, 1); chk("R8 latency data", pix_out, 8'h01);
    send_code(8'h9D); send(8'h05, 1'b1);
    repeat (3) send(8'h10, 1'b1);
    expq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'hFF, 8'h00, 8'h00, 8'h9D, 8'h05};
    cmp_stream("R8 pin-mode stream");
  endtask

  task automatic t_switch();
    do_reset();
    cfg_use_codes = 1'b1; cfg_h_fall = 1'b1;
    tick(); chk("R9 no switch idle", src_codes, 0);
    href_in = 1'b1; tick(); chk("R9 no switch on rise", src_codes, 0);
    href_in = 1'b0; tick(); chk("R9 switch at line start", src_codes, 1);
    chk("R9 trig at switch", h_trig, 1);
  endtask

  task automatic t_codes();
    t_switch();
    send(8'h11, 1'b1);
    send_code(8'h9D);
    chk("R10 EAV no trig (fall sel)", h_trig, 0); chk("R10 F0", field_id, 0);
    send(8'h22, 1'b1);
    send(8'hFF, 1'b1); send(8'h00, 1'b1); send(8'h12, 1'b1);
    chk("R11 partial no trig", h_trig, 0);
    send_code(8'h85);
    chk("R10 SAV trig", h_trig, 1); chk("R10 V flat", v_trig, 0);
    tick(); chk("R10 trig one cycle", h_trig, 0);
    send(8'h33, 1'b1);
    send_code(8'hB3);
    chk("R10 V rise trig", v_trig, 1); chk("R10 H rise ignored", h_trig, 0);
    send_code(8'hC7);
    chk("R10 H fall trig", h_trig, 1); chk("R10 V fall ignored", v_trig, 0);
    chk("R10 F1", field_id, 1);
    href_in = 1'b1; vref_in = 1'b1; tick();
    chk("R12 pin h ignored", h_trig, 0); chk("R12 pin v ignored", v_trig, 0);
    href_in = 1'b0; vref_in = 1'b0; tick();
    chk("R12 pin h fall ignored", h_trig, 0); chk("R12 fid kept", field_id, 1);
    repeat (3) send(8'h44, 1'b1);
    expq = '{8'h11, 8'h22, 8'hFF, 8'h00, 8'h12, 8'h33};
    cmp_stream("R11 code-mode stream");
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_h_edges();
    t_v_edges();
    t_phase_fid();
    t_level_fid();
    t_qual_pol();
    t_gated();
    t_pass();
    t_codes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule